// File: doc/BRIEF.md
# Per-Pipe Buffer-Empty Interrupt Aggregator

This block collects buffer-empty events from ten endpoint pipes and turns them into one interrupt request. Each pipe has a sticky status bit, which is set whenever that pipe reports an event, and an enable bit that software controls. The interrupt request is a level. It is high while any pipe has both its status bit and its enable bit set.

Software reaches both registers through a small 16-bit register port. Status bits are cleared by writing zero to them. Writing one to a status bit leaves it as it is, so software can clear selected pipes without disturbing events that arrive at the same time. The block also covers one corner case. Software may turn on an enable bit while some status bit is already pending. In that case the block adds a one-cycle pulse to the request, so an edge-sensitive interrupt controller still sees a fresh request.

The address map is fixed. Address 0 selects the enable register and address 1 selects the status register. In both registers, bit n belongs to pipe n. Every other address reads as zero. Reads are combinational and have no side effects.

Top module: `pipe_irq_agg`

## Requirements
- R1: After reset the enable register and the status register both read 0, and `irq_o` is 0.
- R2: A write to address 0 loads bits 9..0 of the write data into the enable register. Bit n enables pipe n, and a read of address 0 returns the stored value.
- R3: Bits 15..10 of every read are 0, and write data in bits 15..10 has no effect.
- R4: A 1 on `pipe_evt[n]` sets status bit n (address 1, bit n) at the next clock edge, whatever the state of enable bit n.
- R5: `irq_o` is 1 in every cycle in which at least one pipe has both its status bit and its enable bit set.
- R6: An event on a pipe whose enable bit is 0 does not raise `irq_o`.
- R7: A write to address 1 clears each status bit written as 0 and leaves each status bit written as 1 unchanged.
- R8: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: When a write to address 0 turns some enable bit from 0 to 1 while any status bit is 1, `irq_o` is high for the cycle after that write, even if the pipe just enabled has no pending status.
- R10: A write that turns on enable bits while every status bit is 0 produces no pulse on `irq_o`.
- R11: Reads change no state. Repeated reads of address 1 return the same value, and addresses 2 and 3 read 0.
- R12: `irq_o` returns to 0 once no enabled pipe has a pending status bit, whether the status bits were cleared or the enable bits were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address: 0 = enable, 1 = status |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| pipe_evt | input | 10 | Buffer-empty event per pipe, one cycle per event |
| irq_o | output | 1 | Interrupt request |

## Verification
The directed stimulus covers several cases. Events arrive on disabled pipes, which shows whether status capture depends on the enable bits. Events arrive on enabled pipes, which tests the level path. Enables are turned on with status pending and with nothing pending, which shows the re-raise pulse apart from the steady level. A clear lands in the same cycle as an event, which confirms that the event wins. Status is cleared through a partial mask, which shows whether writing a 1 really preserves the bit. A long run of mixed random writes and events is then compared, cycle by cycle, against a behavioural model. That run catches interactions the directed cases miss, such as back-to-back enable writes or pulses that land on a level which is already high.

// File: rtl/pipe_irq_pkg.sv
package pipe_irq_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_NONE   = 2'd2
  } reg_sel_e;

  // Next value of one status bit: cleared by a write of 0, an event wins.
  function automatic logic f_status_next(input logic cur, input logic clr_wr,
                                         input logic keep, input logic evt);
    logic kill;
    kill = clr_wr & ~keep;
    return (cur & ~kill) | evt;
  endfunction

  // One enable bit turning on.
  function automatic logic f_turns_on(input logic old_v, input logic new_v);
    return new_v & ~old_v;
  endfunction

  // Map an address to a register selector.
  function automatic reg_sel_e f_decode(input logic [1:0] a);
    case (a)
      2'd0:    return SEL_ENABLE;
      2'd1:    return SEL_STATUS;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pia_enable_reg.sv
module pia_enable_reg
  import pipe_irq_pkg::*;
#(
  parameter int N  = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] en_full_q,
  output logic [N-1:0]  rise_o
);
  localparam logic [DW-1:0] VALID_MASK = DW'((64'd1 << N) - 64'd1);

  logic [DW-1:0] en_d;

  always_comb begin
    en_d = wr_hit ? (wr_data & VALID_MASK) : en_full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_full_q <= '0;
    else        en_full_q <= en_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise_o[i] = wr_hit & f_turns_on(en_full_q[i], wr_data[i]);
  end
endmodule

// File: rtl/pia_status_reg.sv
module pia_status_reg
  import pipe_irq_pkg::*;
#(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_hit,
  input  logic [N-1:0] keep_mask,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] st_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic nxt;
    always_comb nxt = f_status_next(st_q[i], clr_hit, keep_mask[i], evt_i[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= nxt;
    end
  end
endmodule

// File: rtl/pia_rearm.sv
module pia_rearm #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] st_q,
  input  logic [N-1:0] en_q,
  output logic         summary_o,
  output logic         pulse_q
);
  logic any_pending;
  logic any_rise;

  assign any_pending = |st_q;
  assign any_rise    = |rise_i;
  assign summary_o   = |(st_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= any_rise & any_pending;
  end
endmodule

// File: rtl/pia_read_mux.sv
module pia_read_mux
  import pipe_irq_pkg::*;
#(
  parameter int N  = 10,
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] en_full,
  input  logic [N-1:0]  st,
  output logic [DW-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    sel = f_decode(2'(addr));
    case (sel)
      SEL_ENABLE: rdata = en_full;
      SEL_STATUS: rdata = DW'(st);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/pipe_irq_agg.sv
module pipe_irq_agg
  import pipe_irq_pkg::*;
#(
  parameter int N  = 10,
  parameter int DW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [N-1:0]  pipe_evt,
  output logic          irq_o
);
  reg_sel_e      wsel;
  logic          en_wr_hit;
  logic          st_wr_hit;
  logic [DW-1:0] en_full_q;
  logic [N-1:0]  enable_q;
  logic [N-1:0]  status_q;
  logic [N-1:0]  rise;
  logic          summary;
  logic          rearm_pulse;

  assign wsel      = f_decode(2'(reg_addr));
  assign en_wr_hit = reg_wr & (wsel == SEL_ENABLE);
  assign st_wr_hit = reg_wr & (wsel == SEL_STATUS);
  assign enable_q  = en_full_q[N-1:0];

  pia_enable_reg #(.N(N), .DW(DW)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_hit(en_wr_hit), .wr_data(reg_wdata),
    .en_full_q(en_full_q), .rise_o(rise)
  );

  pia_status_reg #(.N(N)) u_st (
    .clk(clk), .rst_n(rst_n), .clr_hit(st_wr_hit), .keep_mask(reg_wdata[N-1:0]),
    .evt_i(pipe_evt), .st_q(status_q)
  );

  pia_rearm #(.N(N)) u_rearm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .st_q(status_q), .en_q(enable_q),
    .summary_o(summary), .pulse_q(rearm_pulse)
  );

  pia_read_mux #(.N(N), .DW(DW), .AW(AW)) u_rd (
    .addr(reg_addr), .en_full(en_full_q), .st(status_q), .rdata(reg_rdata)
  );

  assign irq_o = summary | rearm_pulse;
endmodule

// File: rtl/pipe_irq_agg_chk.sv
module pipe_irq_agg_chk #(
  parameter int N  = 10,
  parameter int DW = 16,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [DW-1:0] reg_rdata,
  input logic [N-1:0]  pipe_evt,
  input logic          irq_o,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  enable_q,
  input logic          rearm_pulse
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:N] == '0); // R3

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    |pipe_evt |=> ((status_q & $past(pipe_evt)) == $past(pipe_evt))); // R4

  AST_NO_SET_WITHOUT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(pipe_evt)) == '0)); // R7

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & enable_q)) |-> irq_o); // R5

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|(status_q & enable_q)) || rearm_pulse)); // R6

  AST_PULSE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_pulse |-> $past(|status_q)); // R9

  AST_NO_PULSE_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> !rearm_pulse); // R10
endmodule

bind pipe_irq_agg pipe_irq_agg_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rdata(reg_rdata),
  .pipe_evt(pipe_evt), .irq_o(irq_o), .status_q(status_q),
  .enable_q(enable_q), .rearm_pulse(rearm_pulse)
);

// File: tb/sim_pipe_irq_agg.sv
`timescale 1ns/1ps
module sim_pipe_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0]  pipe_evt = '0;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  pipe_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pipe_evt(pipe_evt), .irq_o(irq_o)
  );

  // Behavioural reference model
  int m_en = 0;
  int m_st = 0;
  bit m_pulse = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_st <= 0; m_pulse <= 0;
    end else begin
      int ns;
      bit turned_on;
      ns = m_st;
      turned_on = 0;
      if (reg_wr && reg_addr == 2'd1) begin
        for (int b = 0; b < 10; b++)
          if (!reg_wdata[b]) ns = ns & ~(1 << b);
      end
      for (int b = 0; b < 10; b++)
        if (pipe_evt[b]) ns = ns | (1 << b);
      if (reg_wr && reg_addr == 2'd0) begin
        for (int b = 0; b < 10; b++)
          if (reg_wdata[b] && ((m_en >> b) & 1) == 0) turned_on = 1;
        m_en <= int'(reg_wdata) & 'h3FF;
      end
      m_pulse <= turned_on && (m_st != 0);
      m_st <= ns;
    end
  end

  function automatic int exp_rd(input logic [1:0] a);
    if (a == 2'd0) return m_en;
    if (a == 2'd1) return m_st;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (live) begin
      chk("R5 irq vs model", int'(irq_o), int'(((m_st & m_en) != 0) || m_pulse));
      chk("R2 rdata vs model", int'(reg_rdata), exp_rd(reg_addr));
    end
  end

  task automatic drive(input bit we, input logic [1:0] a, input logic [15:0] d,
                       input logic [9:0] ev);
    @(negedge clk);
    reg_wr = we; reg_addr = a; reg_wdata = d; pipe_evt = ev;
    @(negedge clk);
    reg_wr = 1'b0; pipe_evt = '0;
    #1;
  endtask

  task automatic peek(input logic [1:0] a, input string tag, input int exp);
    reg_addr = a;
    #0.5;
    chk(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog R1..: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    #1;
    peek(2'd0, "R1 enable after reset", 0);
    peek(2'd1, "R1 status after reset", 0);
    chk("R1 irq after reset", int'(irq_o), 0);

    drive(1, 2'd0, 16'hFFFF, '0);
    peek(2'd0, "R2 enable readback", 'h3FF);
    chk("R3 reserved bits read 0", int'(reg_rdata >> 10), 0);
    chk("R10 no pulse with nothing pending", int'(irq_o), 0);

    drive(1, 2'd0, 16'h0000, '0);
    drive(0, 2'd0, 16'h0000, 10'h010);
    peek(2'd1, "R4 disabled event sets status", 'h010);
    chk("R6 disabled event no irq", int'(irq_o), 0);

    drive(1, 2'd0, 16'h0020, '0);
    chk("R9 rearm pulse high", int'(irq_o), 1);
    drive(0, 2'd0, 16'h0000, '0);
    chk("R9 rearm pulse one cycle", int'(irq_o), 0);

    drive(0, 2'd0, 16'h0000, 10'h020);
    chk("R5 enabled event raises irq", int'(irq_o), 1);
    peek(2'd1, "R4 status accumulates", 'h030);

    drive(1, 2'd1, 16'h03DF, '0);
    peek(2'd1, "R7 clear by zero keep by one", 'h010);
    chk("R12 irq drops after clear", int'(irq_o), 0);

    drive(1, 2'd1, 16'h0000, 10'h001);
    peek(2'd1, "R8 event wins over clear", 'h001);
    chk("R6 pipe0 disabled no irq", int'(irq_o), 0);

    peek(2'd1, "R11 read repeat 1", 'h001);
    peek(2'd1, "R11 read repeat 2", 'h001);
    peek(2'd2, "R11 addr2 reads 0", 0);
    peek(2'd3, "R11 addr3 reads 0", 0);
    peek(2'd1, "R11 status unchanged by reads", 'h001);

    drive(1, 2'd0, 16'h0021, '0);
    chk("R9 enable pending pipe pulse", int'(irq_o), 1);
    drive(0, 2'd0, 16'h0000, '0);
    chk("R5 level holds after pulse", int'(irq_o), 1);
    drive(1, 2'd0, 16'h0020, '0);
    chk("R12 irq drops after disable", int'(irq_o), 0);

    drive(0, 2'd0, 16'h0000, 10'h3FF);
    peek(2'd1, "R4 all pipes set", 'h3FF);
    drive(1, 2'd1, 16'hFC00, '0);
    peek(2'd1, "R7 full clear", 0);
    drive(1, 2'd0, 16'h0000, '0);
    drive(1, 2'd0, 16'h03DF, '0);
    chk("R10 no pulse on idle enable", int'(irq_o), 0);

    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom_range(0, 7));
      drive(r < 3, 2'(r), 16'($urandom), ((r & 1) != 0) ? 10'(1 << (k % 10)) : 10'd0);
    end

    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule